// File: doc/BRIEF.md
# Hardware Cursor Overlay Compositor

This block draws a small two-bit-per-pixel cursor on top of the graphics pixel stream of a raster display. For each incoming pixel it receives the raster coordinate and the 24-bit graphics colour. It then returns either that colour unchanged or one of three cursor colours, one clock later.

Software controls the cursor through four 32-bit registers on a simple memory-mapped bus. One register holds the enable flag and the pattern address. One holds the location. Two hold the colours. Writes to every register pass through a fixed mask. The cursor shape sits in an internal pattern RAM of one row per cursor line, loaded through a dedicated write port.

Each 2-bit pattern code selects a result. Code 0 is transparent. Codes 1 to 3 select a colour stored as RGB565, which is widened to 8 bits per channel before it is output.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, pix_out and pix_valid_out are 0, and all four registers read 0.
- R2: Register index 0 (control) keeps only the bits of write data selected by mask 0x8FFFFFF0. Bit 31 enables the cursor and bits 25:4 hold the pattern address. It reads back the masked value.
- R3: Register index 1 (location) keeps write data masked with 0x0FFF0FFF. Cursor x is bits 10:0 and cursor y is bits 26:16. It reads back the masked value.
- R4: Register index 2 holds the full 32-bit value: colour 1 is in bits 15:0 and colour 2 in bits 31:16. Register index 3 is masked with 0x0000FFFF and holds colour 3 in bits 15:0. Codes 1, 2 and 3 select colours 1, 2 and 3.
- R5: A selected RGB565 colour c is output as {c[15:11],000, c[10:5],00, c[4:0],000}, with red in pix_out bits 23:16, green in 15:8 and blue in 7:0.
- R6: Pattern code 0 passes the graphics pixel through unchanged.
- R7: The cursor affects a line only when cursor_y <= pix_y < cursor_y + 64. The pattern row used is pix_y - cursor_y.
- R8: The cursor covers only pixels with cursor_x <= pix_x < cursor_x + 64. The pattern column is pix_x - cursor_x, and column k is read from bits 2k+1:2k of the row.
- R9: While the enable bit is clear, pix_out equals the input pixel at every coordinate.
- R10: pix_out and pix_valid_out reflect the inputs sampled at the previous rising clock edge.
- R11: When pat_we is high at a rising edge, pat_data is stored as row pat_row of the pattern. Later lines use that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the indexed register (combinational) |
| pat_we | input | 1 | Pattern row write strobe |
| pat_row | input | 6 | Pattern row to write |
| pat_data | input | 128 | Pattern row contents, 2 bits per pixel |
| pix_valid_in | input | 1 | Input pixel valid |
| pix_x | input | 11 | Raster column of the input pixel |
| pix_y | input | 11 | Raster line of the input pixel |
| pix_in | input | 24 | Graphics pixel, RGB888 |
| pix_valid_out | output | 1 | Delayed pixel valid |
| pix_out | output | 24 | Composited pixel, RGB888 |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle delay of the valid strobe;
- pass-through while the cursor is disabled;
- pass-through above the cursor window;
- pass-through for transparent codes;
- the zeroed bits of the control register on readback.

Other properties can only be shown by the bench scenarios, where the reference model predicts each pixel:
- the colour selection for each code;
- RGB565 widening;
- the exact window edges on both axes;
- the row and column mapping into the pattern;
- the masks on location and colour writes.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int CUR_W = 64,
  parameter int CUR_H = 64,
  parameter int XY_W  = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [1:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic                 pat_we,
  input  logic [5:0]           pat_row,
  input  logic [2*CUR_W-1:0]   pat_data,
  input  logic                 pix_valid_in,
  input  logic [XY_W-1:0]      pix_x,
  input  logic [XY_W-1:0]      pix_y,
  input  logic [23:0]          pix_in,
  output logic                 pix_valid_out,
  output logic [23:0]          pix_out
);
  localparam int COL_W = $clog2(CUR_W);
  localparam int ROW_W = $clog2(CUR_H);
  localparam logic [31:0] CTRL_MASK = 32'h8FFF_FFF0;
  localparam logic [31:0] LOC_MASK  = 32'h0FFF_0FFF;
  localparam logic [31:0] COL3_MASK = 32'h0000_FFFF;

  logic [31:0] ctrl_q, loc_q, col12_q, col3_q;
  logic [2*CUR_W-1:0] pat_mem [CUR_H];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      loc_q   <= '0;
      col12_q <= '0;
      col3_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        2'd0: ctrl_q  <= bus_wdata & CTRL_MASK;
        2'd1: loc_q   <= bus_wdata & LOC_MASK;
        2'd2: col12_q <= bus_wdata;
        default: col3_q <= bus_wdata & COL3_MASK;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0: bus_rdata = ctrl_q;
      2'd1: bus_rdata = loc_q;
      2'd2: bus_rdata = col12_q;
      default: bus_rdata = col3_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (pat_we) pat_mem[pat_row[ROW_W-1:0]] <= pat_data;
  end

  wire            cur_en = ctrl_q[31];
  wire [XY_W-1:0] cur_x  = loc_q[XY_W-1:0];
  wire [XY_W-1:0] cur_y  = loc_q[16 +: XY_W];

  wire [XY_W:0] dx = {1'b0, pix_x} - {1'b0, cur_x};
  wire [XY_W:0] dy = {1'b0, pix_y} - {1'b0, cur_y};
  wire in_x = (pix_x >= cur_x) && (dx < (XY_W+1)'(CUR_W));
  wire in_y = (pix_y >= cur_y) && (dy < (XY_W+1)'(CUR_H));
  wire hit  = cur_en && in_x && in_y;

  wire [2*CUR_W-1:0] row_bits = pat_mem[dy[ROW_W-1:0]];
  wire [1:0]         code     = hit ? row_bits[{dx[COL_W-1:0], 1'b0} +: 2] : 2'd0;

  logic [15:0] c565;
  always_comb begin
    case (code)
      2'd1:    c565 = col12_q[15:0];
      2'd2:    c565 = col12_q[31:16];
      default: c565 = col3_q[15:0];
    endcase
  end

  wire [23:0] c888 = {c565[15:11], 3'b0, c565[10:5], 2'b0, c565[4:0], 3'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid_out <= 1'b0;
      pix_out       <= '0;
    end else begin
      pix_valid_out <= pix_valid_in;
      pix_out       <= (code == 2'd0) ? pix_in : c888;
    end
  end

  logic primed;
  always_ff @(posedge clk) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assert_valid_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (pix_valid_out == $past(pix_valid_in)));

  assert_bypass_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(ctrl_q[31])) |-> (pix_out == $past(pix_in)));

  assert_above_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(pix_y < loc_q[16 +: XY_W])) |-> (pix_out == $past(pix_in)));

  assert_transparent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(row_bits[{dx[COL_W-1:0], 1'b0} +: 2] == 2'd0)) |-> (pix_out == $past(pix_in)));

  assert_ctrl_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> ((bus_rdata & ~CTRL_MASK) == 32'd0));
endmodule

// File: tb/sim_cursor_overlay.sv
module sim_cursor_overlay;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic pat_we = 0;
  logic [5:0] pat_row = 0;
  logic [127:0] pat_data = 0;
  logic pix_valid_in = 0;
  logic [10:0] pix_x = 0, pix_y = 0;
  logic [23:0] pix_in = 0, pix_out;
  logic pix_valid_out;

  always #10 clk = ~clk;

  cursor_overlay u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pat_we(pat_we), .pat_row(pat_row),
    .pat_data(pat_data), .pix_valid_in(pix_valid_in), .pix_x(pix_x), .pix_y(pix_y),
    .pix_in(pix_in), .pix_valid_out(pix_valid_out), .pix_out(pix_out));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_reg [4];
  logic [127:0] m_pat [64];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] model(int x, int y, logic [23:0] pin);
    int cx, cy, code;
    logic [15:0] c;
    cx = m_reg[1] & 32'h7FF;
    cy = (m_reg[1] >> 16) & 32'h7FF;
    if (!m_reg[0][31]) return pin;
    if (y < cy || y >= cy + 64 || x < cx || x >= cx + 64) return pin;
    code = m_pat[y - cy][2*(x - cx) +: 2];
    if (code == 0) return pin;
    if (code == 1) c = m_reg[2][15:0];
    else if (code == 2) c = m_reg[2][31:16];
    else c = m_reg[3][15:0];
    return {c[15:11], 3'b000, c[10:5], 2'b00, c[4:0], 3'b000};
  endfunction

  function automatic logic [23:0] gfx(int x, int y);
    return {x[7:0] ^ 8'h5A, y[7:0], x[7:0] + y[7:0]};
  endfunction

  task automatic reg_write(int a, logic [31:0] d);
    bus_wr = 1; bus_addr = a[1:0]; bus_wdata = d;
    @(posedge clk);
    case (a)
      0: m_reg[0] = d & 32'h8FFFFFF0;
      1: m_reg[1] = d & 32'h0FFF0FFF;
      2: m_reg[2] = d;
      default: m_reg[3] = d & 32'h0000FFFF;
    endcase
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic reg_check(string tag, int a, logic [31:0] exp);
    bus_addr = a[1:0];
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic pixel(string tag, int x, int y, bit v);
    logic [23:0] e;
    pix_x = x[10:0]; pix_y = y[10:0]; pix_in = gfx(x, y); pix_valid_in = v;
    e = model(x, y, gfx(x, y));
    @(posedge clk);
    @(negedge clk);
    check(tag, {8'h0, pix_out}, {8'h0, e});
    check("R10", {31'h0, pix_valid_out}, {31'h0, v});
  endtask

  task automatic load_pattern(int salt);
    for (int r = 0; r < 64; r++) begin
      logic [127:0] row;
      for (int c = 0; c < 64; c++) row[2*c +: 2] = 2'((r + c + salt + (r >> 3)) % 4);
      pat_we = 1; pat_row = r[5:0]; pat_data = row;
      @(posedge clk);
      m_pat[r] = row;
      @(negedge clk);
    end
    pat_we = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = 0;
    repeat (3) @(negedge clk);
    check("R1", {8'h0, pix_out}, 32'h0);
    check("R1", {31'h0, pix_valid_out}, 32'h0);
    for (int i = 0; i < 4; i++) reg_check("R1", i, 32'h0);
    rst_n = 1;
    @(negedge clk);

    reg_write(0, 32'hFFFFFFFF); reg_check("R2", 0, 32'h8FFFFFF0);
    reg_write(1, 32'hFFFFFFFF); reg_check("R3", 1, 32'h0FFF0FFF);
    reg_write(3, 32'hFFFFFFFF); reg_check("R4", 3, 32'h0000FFFF);
    reg_write(2, 32'h12345678); reg_check("R4", 2, 32'h12345678);
    reg_write(0, 32'h7123456F); reg_check("R2", 0, 32'h01234560);

    load_pattern(1);
    reg_write(0, 32'h0);
    reg_write(1, (32'd20 << 16) | 32'd10);
    for (int y = 18; y < 90; y += 7)
      for (int x = 5; x < 80; x += 3) pixel("R9", x, y, 1);

    reg_write(2, {16'hF81F, 16'h07E0});
    reg_write(3, 32'hABCD001F);
    reg_write(1, 32'hF032F064);
    reg_write(0, 32'h80000100);
    foreach (m_reg[i]) ;
    for (int y = 49; y <= 52; y++)
      for (int x = 98; x < 166; x++) pixel("R7", x, y, x[0]);
    for (int y = 112; y <= 114; y++)
      for (int x = 98; x < 166; x++) pixel("R8", x, y, 1);
    for (int x = 99; x <= 101; x++) pixel("R6", x, 60, 1);
    for (int x = 162; x <= 165; x++) pixel("R8", x, 70, 1);
    reg_write(2, 32'hFFFF0000);
    reg_write(3, 32'h00008410);
    for (int x = 100; x < 164; x++) pixel("R5", x, 80, 1);

    load_pattern(2);
    for (int y = 50; y < 114; y += 9)
      for (int x = 100; x < 164; x += 5) pixel("R11", x, y, 1);

    reg_write(1, (32'd0 << 16) | 32'd0);
    for (int y = 0; y < 66; y += 13)
      for (int x = 0; x < 66; x += 4) pixel("R4", x, y, 1);
    pixel("R10", 3, 3, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule